// File: doc/BRIEF.md
# Frequency Synthesizer Control and Output Divider

This block is the digital control part of a PLL-based frequency synthesizer. It holds the synthesizer configuration: a 9-bit feedback count handed to an external feedback divider, and a 2-bit select for the divider that follows the PLL. Software or board logic can write the configuration in two ways. One is a serial port: a data line, a shift clock and a transfer strobe. The other is a set of parallel pins with their own strobe. Both paths end in one configuration store. That store acts as a level-sensitive latch: each path has its own open level, and the two levels are of opposite polarity.

The block also forms the output clock. It divides its timing clock by the ratio the select field picks, and gates the result with an output enable. The enable is resampled only while the divided clock is low, so the output always starts and stops cleanly. A small multiplexer chooses which of two reference clocks feeds the PLL.

All logic runs on `clk_i`, which is taken as twice the VCO rate. A post-divide ratio of R therefore gives an output that is high for R cycles of `clk_i` and low for R cycles. The serial clock and both strobes are assumed slow compared with `clk_i`, and are sampled on it.

Top module: `fsynth_ctrl`

## Requirements
- R1: While `pload_i` is low, the configuration follows the parallel pins: `m_o` and `n_o` equal the `pm_i` and `pn_i` values sampled on the previous rising edge of `clk_i`.
- R2: While `pload_i` is high and `sload_i` is low, `m_o` and `n_o` hold their value. Changes on the parallel pins and serial shifting do not alter them.
- R3: Each rising edge of `sclk_i` shifts `sdata_i` into an 11-bit register, most significant bit first. After 11 shifts the first bit sent lands in N[1], then N[0], then M[8] down to M[0].
- R4: While `sload_i` is high and `pload_i` is high, the configuration follows the shift register one cycle later. It keeps its last value after `sload_i` falls.
- R5: When `pload_i` is low and `sload_i` is high at the same time, the parallel pins win.
- R6: `n_o` selects the post-divide ratio R as follows: 00 gives 2, 01 gives 4, 10 gives 8, 11 gives 1. With the output enabled, `fout_o` is high for R cycles and low for R cycles.
- R7: Toggling `oe_i` at any phase never yields a high pulse on `fout_o` shorter or longer than R cycles. The internal gate only changes while the divided phase is low.
- R8: With `oe_i` low, `fout_o` stays low.
- R9: `ref_o` carries `ref_xtal_i` when `ref_sel_i` is high, and `ref_ext_i` when it is low.
- R10: After reset, `m_o` and `n_o` are zero and `fout_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timing clock, twice the VCO rate |
| rst_ni | input | 1 | Active-low synchronous reset |
| sclk_i | input | 1 | Serial shift clock |
| sdata_i | input | 1 | Serial data, most significant bit first |
| sload_i | input | 1 | Serial transfer strobe, open when high |
| pload_i | input | 1 | Parallel strobe, open when low |
| pm_i | input | 9 | Parallel feedback count |
| pn_i | input | 2 | Parallel post-divide select |
| oe_i | input | 1 | Output enable, active high |
| ref_sel_i | input | 1 | Reference select: 1 crystal, 0 external |
| ref_ext_i | input | 1 | External reference clock |
| ref_xtal_i | input | 1 | Crystal oscillator reference clock |
| ref_o | output | 1 | Selected reference to the PLL |
| m_o | output | 9 | Feedback count to the external divider |
| n_o | output | 2 | Active post-divide select |
| fout_o | output | 1 | Divided and gated output clock |

## Verification
Every 9-bit count is loaded with all four select values through the parallel pins. This exposes any bit swap or stuck bit in the store. The serial path is tried with walking-one counts, alternating patterns and the extremes. These show whether the shift order and the N/M split are right.

Each select value is then measured for its high and low run lengths. This separates the irregular ratio encoding from a plain power-of-two one. The enable is toggled at every offset within an output period, to show that no clipped pulse ever appears.

Holding each strobe closed while the other inputs move, and opening both at once, separates hold, transparency and priority.

// File: rtl/fsynth_pkg.sv
`timescale 1ns/1ps
package fsynth_pkg;
  localparam int unsigned SEL_W = 2;

  // post-divide ratio picked by the select field
  function automatic int unsigned post_ratio(input logic [SEL_W-1:0] sel);
    case (sel)
      2'b00:   return 2;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/fsynth_cfg_store.sv
`timescale 1ns/1ps
module fsynth_cfg_store
  import fsynth_pkg::*;
#(
  parameter int unsigned M_W = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sclk,
  input  logic                        sdata,
  input  logic                        sload,
  input  logic                        pload,
  input  logic [M_W-1:0]              pm,
  input  logic [SEL_W-1:0]            pn,
  output logic [M_W-1:0]              m,
  output logic [SEL_W-1:0]            n,
  output logic [M_W+SEL_W-1:0]        sr,
  output logic                        shift_ev
);
  localparam int unsigned SR_W = M_W + SEL_W;

  logic            sclk_q;
  logic [SR_W-1:0] sr_q;
  logic [SR_W-1:0] cfg_q;
  logic            par_open;
  logic            ser_open;

  assign shift_ev = sclk & ~sclk_q;
  assign par_open = ~pload;
  assign ser_open = sload & pload;   // parallel side wins when both open

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      sr_q   <= '0;
      cfg_q  <= '0;
    end else begin
      sclk_q <= sclk;
      if (shift_ev) sr_q <= {sr_q[SR_W-2:0], sdata};
      if (par_open)      cfg_q <= {pn, pm};
      else if (ser_open) cfg_q <= sr_q;
    end
  end

  assign n  = cfg_q[SR_W-1 -: SEL_W];
  assign m  = cfg_q[M_W-1:0];
  assign sr = sr_q;
endmodule

// File: rtl/fsynth_post_div.sv
`timescale 1ns/1ps
module fsynth_post_div
  import fsynth_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             oe,
  output logic             out,
  output logic             phase,
  output logic             gate,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic             phase_q, phase_d;
  logic             gate_q, gate_d;
  logic             out_q;

  always_comb begin
    lim     = CNT_W'(post_ratio(sel) - 1);
    wrap    = (cnt_q >= lim);
    cnt_d   = wrap ? '0 : cnt_q + 1'b1;
    phase_d = wrap ? ~phase_q : phase_q;
    // enable may only be taken while the next phase is low
    gate_d  = phase_d ? gate_q : oe;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
      gate_q  <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
      gate_q  <= gate_d;
      out_q   <= phase_d & gate_d;
    end
  end

  assign out   = out_q;
  assign phase = phase_q;
  assign gate  = gate_q;
endmodule

// File: rtl/fsynth_ref_mux.sv
`timescale 1ns/1ps
module fsynth_ref_mux (
  input  logic sel_xtal,
  input  logic ref_ext,
  input  logic ref_xtal,
  output logic ref_out
);
  assign ref_out = sel_xtal ? ref_xtal : ref_ext;
endmodule

// File: rtl/fsynth_ctrl.sv
`timescale 1ns/1ps
module fsynth_ctrl
  import fsynth_pkg::*;
#(
  parameter int unsigned M_W   = 9,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             sdata_i,
  input  logic             sload_i,
  input  logic             pload_i,
  input  logic [M_W-1:0]   pm_i,
  input  logic [1:0]       pn_i,
  input  logic             oe_i,
  input  logic             ref_sel_i,
  input  logic             ref_ext_i,
  input  logic             ref_xtal_i,
  output logic             ref_o,
  output logic [M_W-1:0]   m_o,
  output logic [1:0]       n_o,
  output logic             fout_o
);
  logic [M_W+SEL_W-1:0] sr_w;
  logic                 shift_ev_w;
  logic                 phase_w;
  logic                 gate_w;
  logic                 wrap_w;

  fsynth_cfg_store #(.M_W(M_W)) u_cfg (
    .clk      (clk_i),
    .rst_n    (rst_ni),
    .sclk     (sclk_i),
    .sdata    (sdata_i),
    .sload    (sload_i),
    .pload    (pload_i),
    .pm       (pm_i),
    .pn       (pn_i),
    .m        (m_o),
    .n        (n_o),
    .sr       (sr_w),
    .shift_ev (shift_ev_w)
  );

  fsynth_post_div #(.CNT_W(CNT_W)) u_div (
    .clk   (clk_i),
    .rst_n (rst_ni),
    .sel   (n_o),
    .oe    (oe_i),
    .out   (fout_o),
    .phase (phase_w),
    .gate  (gate_w),
    .wrap  (wrap_w)
  );

  fsynth_ref_mux u_ref (
    .sel_xtal (ref_sel_i),
    .ref_ext  (ref_ext_i),
    .ref_xtal (ref_xtal_i),
    .ref_out  (ref_o)
  );
endmodule

// File: rtl/fsynth_ctrl_chk.sv
`timescale 1ns/1ps
module fsynth_ctrl_chk #(
  parameter int unsigned M_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pload,
  input logic             sload,
  input logic [M_W-1:0]   pm,
  input logic [1:0]       pn,
  input logic [M_W-1:0]   m,
  input logic [1:0]       n,
  input logic [M_W+1:0]   sr,
  input logic             shift_ev,
  input logic             wrap,
  input logic             out,
  input logic             phase,
  input logic             gate
);
  p_par_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pload |=> (m == $past(pm) && n == $past(pn)));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pload && !sload) |=> ($stable(m) && $stable(n)));

  p_ser_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pload && sload) |=> ({n, m} == $past(sr)));

  p_shift_only_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_ev |=> $stable(sr));

  p_gate_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    phase |-> $stable(gate));

  p_high_needs_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out |-> gate);

  p_out_tracks_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out && !wrap) |=> out);
endmodule

bind fsynth_ctrl fsynth_ctrl_chk #(.M_W(M_W)) u_chk (
  .clk      (clk_i),
  .rst_n    (rst_ni),
  .pload    (pload_i),
  .sload    (sload_i),
  .pm       (pm_i),
  .pn       (pn_i),
  .m        (m_o),
  .n        (n_o),
  .sr       (sr_w),
  .shift_ev (shift_ev_w),
  .wrap     (wrap_w),
  .out      (fout_o),
  .phase    (phase_w),
  .gate     (gate_w)
);

// File: tb/fsynth_ctrl_tb.sv
`timescale 1ns/1ps
module fsynth_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, sdata = 1'b0, sload = 1'b0, pload = 1'b1;
  logic [8:0] pm = '0;
  logic [1:0] pn = '0;
  logic       oe = 1'b1, ref_sel = 1'b1, ref_ext = 1'b0, ref_xtal = 1'b0;
  logic       ref_o, fout;
  logic [8:0] m_o;
  logic [1:0] n_o;

  int n_tests = 0;
  int n_fail  = 0;

  fsynth_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata),
    .sload_i(sload), .pload_i(pload), .pm_i(pm), .pn_i(pn), .oe_i(oe),
    .ref_sel_i(ref_sel), .ref_ext_i(ref_ext), .ref_xtal_i(ref_xtal),
    .ref_o(ref_o), .m_o(m_o), .n_o(n_o), .fout_o(fout)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int k);
    repeat (k) @(negedge clk);
  endtask

  function automatic int exp_ratio(input int sel);
    return (sel == 3) ? 1 : (2 << sel);
  endfunction

  task automatic par_load(input int mv, input int nv);
    pm = 9'(mv); pn = 2'(nv); pload = 1'b0; tick(1);
    pload = 1'b1; tick(1);
  endtask

  task automatic ser_bit(input logic b);
    sdata = b; sclk = 1'b1; tick(1);
    sclk = 1'b0; tick(1);
  endtask

  task automatic ser_word(input int mv, input int nv);
    logic [10:0] w;
    w = {2'(nv), 9'(mv)};
    for (int i = 10; i >= 0; i--) ser_bit(w[i]);
  endtask

  task automatic measure(input int r, input string tag);
    int hi = 0, lo = 0, guard = 0;
    while (fout === 1'b1 && guard < 100) begin tick(1); guard++; end
    while (fout === 1'b0 && guard < 200) begin tick(1); guard++; end
    while (fout === 1'b1 && hi < 100) begin hi++; tick(1); end
    while (fout === 1'b0 && lo < 100) begin lo++; tick(1); end
    chk(hi == r, {tag, " high run"}, hi, r);
    chk(lo == r, {tag, " low run"}, lo, r);
  endtask

  // run-length monitor for clipped pulses
  bit mon_en = 1'b0;
  int mon_r = 0, run = 0, bad_runs = 0, runs_seen = 0;
  always @(negedge clk) begin
    if (mon_en) begin
      if (fout) run++;
      else if (run != 0) begin
        runs_seen++;
        if (run != mon_r) bad_runs++;
        run = 0;
      end
    end else run = 0;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int mlist[14];
    tick(5);
    rst_n = 1'b1;
    tick(1);
    // R10 reset state
    chk(m_o == 0, "R10 m after reset", m_o, 0);
    chk(n_o == 0, "R10 n after reset", n_o, 0);
    chk(fout == 0, "R10 fout after reset", fout, 0);

    // R9 reference selection, all combinations
    for (int c = 0; c < 8; c++) begin
      ref_sel = c[2]; ref_xtal = c[1]; ref_ext = c[0];
      #1;
      chk(ref_o == (c[2] ? c[1] : c[0]), "R9 ref mux", ref_o, c[2] ? c[1] : c[0]);
    end
    tick(1);

    // R1 exhaustive parallel sweep
    for (int nv = 0; nv < 4; nv++)
      for (int mv = 0; mv < 512; mv++) begin
        par_load(mv, nv);
        chk(m_o == mv && n_o == nv, "R1 parallel load", {n_o, m_o}, nv * 512 + mv);
      end

    // R1 transparency while strobe held low
    pload = 1'b0; pm = 9'h0A5; pn = 2'd2; tick(1);
    chk(m_o == 9'h0A5, "R1 transparent first", m_o, 9'h0A5);
    pm = 9'h15A; pn = 2'd1; tick(1);
    chk(m_o == 9'h15A && n_o == 1, "R1 transparent second", {n_o, m_o}, 512 + 9'h15A);
    pload = 1'b1; tick(1);

    // R2 hold: pins move, serial shifts, strobes closed
    pm = 9'h0FF; pn = 2'd3; tick(3);
    chk(m_o == 9'h15A && n_o == 1, "R2 pins ignored", {n_o, m_o}, 512 + 9'h15A);
    ser_word(9'h1C3, 2);
    chk(m_o == 9'h15A && n_o == 1, "R2 shifting ignored", {n_o, m_o}, 512 + 9'h15A);

    // R3 / R4 serial sweep
    mlist[0] = 0; mlist[1] = 9'h1FF; mlist[2] = 9'h155; mlist[3] = 9'h0AA; mlist[4] = 9'h13C;
    for (int b = 0; b < 9; b++) mlist[5 + b] = 1 << b;
    for (int nv = 0; nv < 4; nv++)
      for (int k = 0; k < 14; k++) begin
        ser_word(mlist[k], nv);
        sload = 1'b1; tick(1); sload = 1'b0; tick(1);
        chk(m_o == mlist[k] && n_o == nv, "R3 R4 serial load", {n_o, m_o}, nv * 512 + mlist[k]);
      end

    // R4 transparency during strobe high: one more bit shifts config
    ser_word(9'h0C5, 1);               // word 0x2C5
    sload = 1'b1; tick(1);
    ser_bit(1'b1);                      // word becomes 0x58B (11 bits)
    chk({n_o, m_o} == 11'h58B, "R4 serial transparent", {n_o, m_o}, 11'h58B);
    sload = 1'b0; tick(1);
    ser_bit(1'b0);
    chk({n_o, m_o} == 11'h58B, "R4 hold after strobe falls", {n_o, m_o}, 11'h58B);

    // R5 both strobes open: parallel wins
    ser_word(9'h111, 3);
    pm = 9'h022; pn = 2'd0; pload = 1'b0; sload = 1'b1; tick(2);
    chk(m_o == 9'h022 && n_o == 0, "R5 parallel priority", {n_o, m_o}, 9'h022);
    pload = 1'b1; sload = 1'b0; tick(1);

    // R6 ratio for each select value
    oe = 1'b1;
    for (int nv = 0; nv < 4; nv++) begin
      par_load(7, nv);
      tick(40);
      measure(exp_ratio(nv), "R6 ratio");
    end

    // R7 enable toggled at every offset, two ratios
    for (int nv = 1; nv < 3; nv++) begin
      par_load(3, nv);
      oe = 1'b1; tick(40);
      while (fout !== 1'b0) tick(1);
      mon_r = exp_ratio(nv); bad_runs = 0; runs_seen = 0; mon_en = 1'b1;
      for (int off = 0; off < 2 * exp_ratio(nv); off++) begin
        tick(off);
        oe = 1'b0; tick(3 + off % 5);
        oe = 1'b1; tick(20);
      end
      while (fout !== 1'b0) tick(1);
      tick(1);
      mon_en = 1'b0;
      chk(bad_runs == 0, "R7 no clipped pulse", bad_runs, 0);
      chk(runs_seen > 10, "R7 pulses observed", runs_seen, 11);
    end

    // R8 output held low while disabled
    par_load(3, 3);
    oe = 1'b0; tick(10);
    begin
      int highs = 0;
      for (int i = 0; i < 64; i++) begin
        if (fout) highs++;
        tick(1);
      end
      chk(highs == 0, "R8 disabled output low", highs, 0);
    end
    oe = 1'b1; tick(10);
    measure(1, "R8 re-enable R6 ratio");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule